// File: doc/BRIEF.md
# Lane-Splittable Booth Multiplier

This block multiplies two 16-bit operand words. A two-bit mode input decides how the words are split: one 16x16 product, two separate 8x8 products, or four separate 4x4 products. All of them come from one shared radix-4 Booth partial-product array and one carry-save reduction tree. A single control bit picks two's-complement or unsigned arithmetic for every lane at once. It is meant for neural-network datapaths whose layers change operand precision between passes. Narrow weights then get more multiplies per issued word without extra hardware.

The array is cut into lanes at run time. Each lane builds partial products from its own operand slices and extends them only up to its own top result bit. Carries are dropped at lane starts, both in the reduction tree and in the final segmented adder. The packed 32-bit result is registered, so an operand pair is sampled on an edge where the input valid is high. Its result appears together with the output valid on that same edge.

Top module: `varprec_mult`

## Requirements
- R1: With mode 2'b00 the output word is the full 32-bit product of op_a and op_b.
- R2: With mode 2'b01, lane k (k = 0, 1) multiplies op_a[8k+7:8k] by op_b[8k+7:8k] and places its 16-bit product at product[16k+15:16k].
- R3: With mode 2'b10, lane k (k = 0..3) multiplies op_a[4k+3:4k] by op_b[4k+3:4k] and places its 8-bit product at product[8k+7:8k].
- R4: Mode 2'b11 gives exactly the same result as mode 2'b00.
- R5: With is_signed high, every lane treats its slices as two's-complement numbers. With is_signed low, every lane treats them as unsigned. A signed 16-bit product by 1 returns the sign-extended operand.
- R6: A lane's result depends only on its own operand slices. No carry or sign extension reaches a neighbouring lane, even for the largest-magnitude operands.
- R7: out_valid is high on the cycle after each cycle in which in_valid is high, and is low otherwise.
- R8: While rst is high at a clock edge, out_valid and product are cleared to zero on that edge.
- R9: When in_valid is low, product holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | Lane split: 00 one lane, 01 two lanes, 10 four lanes, 11 one lane |
| is_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| op_a | input | 16 | Multiplicand word |
| op_b | input | 16 | Multiplier word (Booth recoded) |
| out_valid | output | 1 | Result valid |
| product | output | 32 | Packed lane products |

## Verification
The datapath holds no state between operations. A wrong Booth digit, a misplaced sign extension or a carry leaking across a lane cut therefore shows up in the product of the very vector that triggers it, one cycle after it is issued. Leaks across lane cuts are provoked with operands that make each lane's partial-product sum overflow its field, such as minimum negative and all-ones slices in both signedness settings. A broken valid or hold path shows up as a misaligned scoreboard pop, or as the product drifting during idle cycles.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_HALF = 2'b01,
    MODE_QUAD = 2'b10,
    MODE_ALT  = 2'b11
  } split_mode_e;

  // Lane width in bits for a given split mode and word width.
  function automatic int lane_width(input logic [1:0] m, input int dw);
    case (m)
      MODE_HALF: return dw / 2;
      MODE_QUAD: return dw / 4;
      default:   return dw;
    endcase
  endfunction

  // Rows left after one 3:2 reduction layer.
  function automatic int rows_after(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

endpackage

// File: rtl/vpm_booth_rows.sv
module vpm_booth_rows #(
  parameter int DW = 16,
  parameter int PW = 2 * DW,
  parameter int NR = DW / 2 + 1
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [1:0]    mode,
  input  logic          is_signed,
  output logic [PW-1:0] rows [NR],
  output logic [PW-1:0] corr
);
  import vpm_pkg::*;

  localparam int MAXL = 4;

  // Bit i of lane slice starting at base; above the slice returns ext.
  function automatic logic slice_bit(input logic [DW-1:0] v, input int base,
                                     input int lw, input logic ext, input int i);
    logic [DW-1:0] t;
    if (i < 0) return 1'b0;
    if (i >= lw) return ext;
    t = v >> (base + i);
    return t[0];
  endfunction

  int   lw, nl, base, s;
  logic ea, eb, hi, mid, lo, one, two, neg, mb;

  always_comb begin
    lw = lane_width(mode, DW);
    nl = DW / lw;
    base = 0; s = 0;
    ea = 1'b0; eb = 1'b0; hi = 1'b0; mid = 1'b0; lo = 1'b0;
    one = 1'b0; two = 1'b0; neg = 1'b0; mb = 1'b0;
    corr = '0;
    for (int r = 0; r < NR; r++) rows[r] = '0;
    for (int k = 0; k < MAXL; k++) begin
      if (k < nl) begin
        base = lw * k;
        // one extra bit per lane: sign copy when signed, zero otherwise
        ea = is_signed & slice_bit(op_a, base, lw, 1'b0, lw - 1);
        eb = is_signed & slice_bit(op_b, base, lw, 1'b0, lw - 1);
        for (int r = 0; r < NR; r++) begin
          if (2 * r <= lw) begin
            hi  = slice_bit(op_b, base, lw, eb, 2 * r + 1);
            mid = slice_bit(op_b, base, lw, eb, 2 * r);
            lo  = slice_bit(op_b, base, lw, eb, 2 * r - 1);
            one = mid ^ lo;
            two = (hi & ~mid & ~lo) | (~hi & mid & lo);
            neg = hi & ~(mid & lo);
            // row field covers only this lane's 2*lw result bits
            for (int q = 0; q < PW; q++) begin
              if (q < 2 * lw) begin
                s  = q - 2 * r;
                mb = two ? slice_bit(op_a, base, lw, ea, s - 1)
                         : slice_bit(op_a, base, lw, ea, s);
                if (s >= 0 && (one | two))
                  rows[r] = rows[r] | (PW'(mb ^ neg) << (2 * base + q));
              end
            end
            corr = corr | (PW'(neg) << (2 * base + 2 * r));
          end
        end
      end
    end
  end

endmodule

// File: rtl/vpm_csa_tree.sv
module vpm_csa_tree #(
  parameter int PW = 32,
  parameter int N  = 2
) (
  input  logic [PW-1:0] rin [N],
  input  logic [PW-1:0] keep,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] car_o
);
  import vpm_pkg::*;

  if (N <= 2) begin : g_leaf
    // last layer always delivers (sum, masked carry); mask is idempotent
    assign sum_o = rin[0];
    assign car_o = rin[1] & keep;
  end else begin : g_layer
    localparam int G = N / 3;
    localparam int M = rows_after(N);
    logic [PW-1:0] nxt [M];

    for (genvar g = 0; g < G; g++) begin : g_csa
      logic [PW-1:0] maj;
      assign nxt[2*g] = rin[3*g] ^ rin[3*g+1] ^ rin[3*g+2];
      assign maj = (rin[3*g] & rin[3*g+1]) | (rin[3*g] & rin[3*g+2])
                 | (rin[3*g+1] & rin[3*g+2]);
      // a carry into a lane's lowest bit is dropped
      assign nxt[2*g+1] = {maj[PW-2:0], 1'b0} & keep;
    end
    for (genvar r = 0; r < N % 3; r++) begin : g_pass
      assign nxt[2*G+r] = rin[3*G+r];
    end

    vpm_csa_tree #(.PW(PW), .N(M)) u_next (
      .rin(nxt), .keep(keep), .sum_o(sum_o), .car_o(car_o)
    );
  end

endmodule

// File: rtl/vpm_seg_adder.sv
module vpm_seg_adder #(
  parameter int PW   = 32,
  parameter int SEG  = 8,
  parameter int NSEG = PW / SEG
) (
  input  logic [PW-1:0]   x,
  input  logic [PW-1:0]   y,
  input  logic [NSEG-2:0] cut,
  output logic [PW-1:0]   sum
);
  logic [NSEG-2:0] co;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic cin;
    if (s == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_link
      assign cin = co[s-1] & ~cut[s-1];
    end
    if (s < NSEG - 1) begin : g_carry
      assign {co[s], sum[s*SEG +: SEG]} =
        {1'b0, x[s*SEG +: SEG]} + {1'b0, y[s*SEG +: SEG]} + {{SEG{1'b0}}, cin};
    end else begin : g_top
      assign sum[s*SEG +: SEG] = x[s*SEG +: SEG] + y[s*SEG +: SEG] + {{(SEG-1){1'b0}}, cin};
    end
  end

endmodule

// File: rtl/varprec_mult.sv
module varprec_mult #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      mode,
  input  logic            is_signed,
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  output logic            out_valid,
  output logic [2*DW-1:0] product
);
  import vpm_pkg::*;

  localparam int PW   = 2 * DW;
  localparam int NR   = DW / 2 + 1;
  localparam int NT   = NR + 1;
  localparam int SEG  = DW / 2;
  localparam int NSEG = PW / SEG;

  logic [PW-1:0]   rows [NR];
  logic [PW-1:0]   corr;
  logic [PW-1:0]   tree_in [NT];
  logic [PW-1:0]   keep, red_s, red_c, sum;
  logic [NSEG-2:0] cut;
  int              lw;

  vpm_booth_rows #(.DW(DW), .PW(PW), .NR(NR)) u_rows (
    .op_a(op_a), .op_b(op_b), .mode(mode), .is_signed(is_signed),
    .rows(rows), .corr(corr)
  );

  for (genvar r = 0; r < NR; r++) begin : g_tin
    assign tree_in[r] = rows[r];
  end
  assign tree_in[NR] = corr;

  // lane starts block carries; segment cuts follow the same boundaries
  always_comb begin
    lw = lane_width(mode, DW);
    keep = '1;
    for (int p = 1; p < PW; p++)
      if (p % (2 * lw) == 0) keep = keep & ~(PW'(1) << p);
    for (int s = 1; s < NSEG; s++)
      cut[s-1] = ((s * SEG) % (2 * lw)) == 0;
  end

  vpm_csa_tree #(.PW(PW), .N(NT)) u_tree (
    .rin(tree_in), .keep(keep), .sum_o(red_s), .car_o(red_c)
  );

  vpm_seg_adder #(.PW(PW), .SEG(SEG), .NSEG(NSEG)) u_cpa (
    .x(red_s), .y(red_c), .cut(cut), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= sum;
    end
  end

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && product == '0));

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(product));

  p_quad_zero_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_QUAD && op_a[DW/4-1:0] == '0)
      |=> product[DW/2-1:0] == '0);

  p_half_isolated_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_HALF && op_b[DW-1:DW/2] == '0)
      |=> product[PW-1:DW] == '0);

  p_signed_unit_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_signed && (mode == MODE_FULL || mode == MODE_ALT)
     && op_a == DW'(1))
      |=> product == {{DW{$past(op_b[DW-1])}}, $past(op_b)});

endmodule

// File: tb/sim_varprec_mult.sv
module sim_varprec_mult;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        is_signed = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        out_valid;
  logic [31:0] product;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_exp = '0;

  always #5 clk = ~clk;

  varprec_mult u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product)
  );

  function automatic logic [31:0] model(input logic [1:0] m, input logic sg,
                                        input logic [15:0] a, input logic [15:0] b);
    int lw;
    longint ak, bk, p, msk;
    logic [31:0] res;
    lw  = (m == 2'b01) ? 8 : (m == 2'b10) ? 4 : 16;
    res = '0;
    for (int k = 0; k < 16 / lw; k++) begin
      msk = (longint'(1) << lw) - 1;
      ak = (longint'(a) >> (lw * k)) & msk;
      bk = (longint'(b) >> (lw * k)) & msk;
      if (sg && ak[lw-1]) ak = ak - (longint'(1) << lw);
      if (sg && bk[lw-1]) bk = bk - (longint'(1) << lw);
      p = (ak * bk) & ((longint'(1) << (2 * lw)) - 1);
      res = res | 32'(p << (2 * lw * k));
    end
    return res;
  endfunction

  function automatic logic [15:0] min_pat(input logic [1:0] m);
    return (m == 2'b01) ? 16'h8080 : (m == 2'b10) ? 16'h8888 : 16'h8000;
  endfunction

  function automatic string mode_tag(input logic [1:0] m, input logic sg);
    string t;
    t = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : (m == 2'b10) ? "R3" : "R4";
    return sg ? {t, " R5"} : t;
  endfunction

  task automatic send(input logic [1:0] m, input logic sg, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
    @(negedge clk);
    mode = m; is_signed = sg; op_a = a; op_b = b; in_valid = 1'b1;
    exp_q.push_back(model(m, sg, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    op_a = $urandom(); op_b = $urandom();
    repeat (n - 1) @(negedge clk);
  endtask

  // scoreboard monitor: sample just after each rising edge
  initial begin
    @(negedge clk);
    wait (!rst);
    forever begin
      @(posedge clk);
      #1;
      if (in_valid || out_valid) begin
        checks++;
        if (out_valid !== in_valid) begin
          fails++;
          $display("FAIL R7 out_valid=%0b expected %0b", out_valid, in_valid);
        end
      end
      if (in_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7 result with empty scoreboard: actual %h expected none", product);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          if (product !== e) begin
            fails++;
            $display("FAIL %s product=%h expected %h", t, product, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: cleared under reset
    checks++;
    if (out_valid !== 1'b0 || product !== 32'h0) begin
      fails++;
      $display("FAIL R8 valid=%0b product=%h expected 0 and 00000000", out_valid, product);
    end
    rst = 1'b0;
    idle(2);

    for (int m = 0; m < 4; m++) begin
      for (int sg = 0; sg < 2; sg++) begin
        logic [1:0] mm;
        string t;
        mm = 2'(m);
        t = mode_tag(mm, 1'(sg));
        send(mm, 1'(sg), 16'h0000, 16'hBEEF, t);
        send(mm, 1'(sg), min_pat(mm), min_pat(mm), t);
        send(mm, 1'(sg), 16'hFFFF, 16'hFFFF, t);
        send(mm, 1'(sg), min_pat(mm), 16'hFFFF, t);
        send(mm, 1'(sg), 16'h0001, 16'h8001, t);
        send(mm, 1'(sg), 16'h7777, 16'h7F7F, t);
        for (int i = 0; i < 30; i++)
          send(mm, 1'(sg), 16'($urandom()), 16'($urandom()), t);
      end
    end

    // R6: a lane overflowing its field must not disturb its neighbours
    send(2'b01, 1'b0, 16'hFF01, 16'hFF01, "R6");
    send(2'b01, 1'b1, 16'h8001, 16'h8001, "R6");
    send(2'b01, 1'b1, 16'h0180, 16'h01FF, "R6");
    send(2'b10, 1'b0, 16'hF1F1, 16'hF1F1, "R6");
    send(2'b10, 1'b1, 16'h8181, 16'hF8F8, "R6");
    send(2'b10, 1'b1, 16'h0F0F, 16'h8F8F, "R6");

    // R7: back-to-back vectors after a gap
    idle(3);
    send(2'b00, 1'b1, 16'h1234, 16'hFEDC, "R7 R1");
    send(2'b10, 1'b0, 16'hABCD, 16'h9876, "R7 R3");

    // R9: product holds while in_valid is low and operands move
    idle(4);
    checks++;
    if (product !== last_exp || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 product=%h valid=%0b expected %h and 0", product, out_valid, last_exp);
    end

    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 pending results=%0d expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule